// File: doc/BRIEF.md
# Data-Set Record Output FIFO

This block queues complete demodulator result records and presents them to a host one field at a time. A record carries five 16-bit values: in-phase (I), quadrature (Q), magnitude, phase and frequency. The upstream datapath delivers all five values together with a single write strobe. The host picks one field of the oldest stored record with a 3-bit selector and reads it on a 16-bit output. It then pulses an advance strobe to retire that record and expose the next.

The block stores records, never single words, so the host always reads the five fields of one record consistently. It holds at most seven records. Empty and full flags report the occupancy, and a sticky overflow flag records that a write was lost. The read word is formed from an upper and a lower byte lane and depends combinationally on the selector and the oldest record.

Top module: `rec_out_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `overflow` is 0 and `rd_data` is 0 for every selector value.
- R2: Records leave in the order they were written. An advance exposes the next older record, with all five fields from the same write.
- R3: Selector code 0 returns I, 1 returns Q, 2 returns magnitude, 3 returns phase and 4 returns frequency, all from the oldest record.
- R4: Selector codes 5, 6 and 7 return 0.
- R5: I, Q, phase and frequency are returned bit-exact as two's complement words. Magnitude is returned with bit 15 forced to 0 and bits 14:0 as written.
- R6: The buffer holds seven records. `full` is 1 exactly when seven are stored.
- R7: A write while seven records are stored is dropped, whether or not an advance happens in the same cycle. It sets `overflow`, which stays 1 until reset.
- R8: An advance while the buffer is empty has no effect. A later write becomes the oldest record.
- R9: With one to six records stored, a write and an advance in the same cycle leave the occupancy unchanged. They retire the oldest record and append the new one.
- R10: While the buffer is empty, `rd_data` is 0 for every selector value.
- R11: `rd_data` follows a change of `rd_sel` in the same cycle, with no clock edge. A write into an empty buffer is readable after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one record |
| wr_i | input | 16 | In-phase value, two's complement |
| wr_q | input | 16 | Quadrature value, two's complement |
| wr_mag | input | 16 | Magnitude value, unsigned |
| wr_phase | input | 16 | Phase value, two's complement |
| wr_freq | input | 16 | Frequency value, two's complement |
| rd_sel | input | 3 | Field selector for the oldest record |
| rd_adv | input | 1 | Retire the oldest record |
| rd_data | output | 16 | Selected field of the oldest record |
| empty | output | 1 | No record stored |
| full | output | 1 | Seven records stored |
| overflow | output | 1 | Sticky: a write was dropped |

## Verification
The bench builds the block with its default parameters: seven records of five 16-bit fields. Because the depth is not a power of two, the pointer wrap from slot 6 back to slot 0 is reached only after more than seven writes. The bench drives that wrap during the fill, the overflow write and the mixed write-and-advance traffic. Magnitude values with bit 15 set check the forced zero, and every selector code, including the three unused ones, is read against the scoreboard head.

// File: rtl/rec_out_fifo_pkg.sv
package rec_out_fifo_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int FLD_I     = 0;
  localparam int FLD_Q     = 1;
  localparam int FLD_MAG   = 2;
  localparam int FLD_PHASE = 3;
  localparam int FLD_FREQ  = 4;

  // Advance a slot index around a ring of arbitrary length
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned len);
    return (idx == len - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/rec_out_fifo_ctrl.sv
module rec_out_fifo_ctrl #(
  parameter int DEPTH = 7,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_adv,
  output logic             push,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             empty,
  output logic             full,
  output logic             overflow
);
  import rec_out_fifo_pkg::*;

  logic [CNT_W-1:0] count_q;
  logic             pop;

  assign push = wr_en && !full;
  assign pop  = rd_adv && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count_q  <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
      if (wr_en && full) overflow <= 1'b1;
      case ({push, pop})
        2'b10: begin
          count_q <= count_q + 1'b1;
          empty   <= 1'b0;
          full    <= (int'(count_q) == DEPTH - 1);
        end
        2'b01: begin
          count_q <= count_q - 1'b1;
          full    <= 1'b0;
          empty   <= (int'(count_q) == 1);
        end
        default: ;
      endcase
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    int'(count_q) <= DEPTH);
  assert_full_holds_R6: assert property (@(posedge clk) disable iff (rst)
    full && wr_en && !rd_adv |=> full);
  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en && full |=> overflow);
  assert_sticky_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  assert_empty_adv_R8: assert property (@(posedge clk) disable iff (rst)
    empty && rd_adv |=> $stable(rd_ptr));
  assert_mixed_count_R9: assert property (@(posedge clk) disable iff (rst)
    !empty && !full && wr_en && rd_adv |=> $stable(count_q));
endmodule

// File: rtl/rec_out_fifo_store.sv
module rec_out_fifo_store #(
  parameter int DEPTH   = 7,
  parameter int FIELD_W = 16,
  parameter int NFIELDS = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                            clk,
  input  logic                            we,
  input  logic [PTR_W-1:0]                waddr,
  input  logic [NFIELDS-1:0][FIELD_W-1:0] wdata,
  input  logic [PTR_W-1:0]                raddr,
  output logic [NFIELDS-1:0][FIELD_W-1:0] rdata
);
  // One small memory per field, written at one slot and read at another
  for (genvar f = 0; f < NFIELDS; f++) begin : g_field
    logic [FIELD_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata[f];
    end
    assign rdata[f] = mem[raddr];
  end
endmodule

// File: rtl/rec_out_fifo_mux.sv
module rec_out_fifo_mux #(
  parameter int FIELD_W = 16,
  parameter int NFIELDS = 5,
  parameter int SEL_W   = 3,
  localparam int LANE_W = FIELD_W / 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NFIELDS-1:0][FIELD_W-1:0] fields,
  input  logic                            valid,
  input  logic [SEL_W-1:0]                sel,
  output logic [FIELD_W-1:0]              data
);
  import rec_out_fifo_pkg::*;

  logic [FIELD_W-1:0] word;
  logic [LANE_W-1:0]  lane_hi, lane_lo;

  always_comb begin
    word = '0;
    if (valid && int'(sel) < NFIELDS) begin
      word = fields[sel];
      if (int'(sel) == FLD_MAG) word[FIELD_W-1] = 1'b0;
    end
  end

  assign lane_hi = word[FIELD_W-1 -: LANE_W];
  assign lane_lo = word[FIELD_W-LANE_W-1:0];
  assign data    = {lane_hi, lane_lo};

  assert_unused_sel_zero_R4: assert property (@(posedge clk) disable iff (rst)
    int'(sel) >= NFIELDS |-> data == '0);
  assert_mag_msb_R5: assert property (@(posedge clk) disable iff (rst)
    int'(sel) == FLD_MAG |-> !data[FIELD_W-1]);
  assert_empty_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !valid |-> data == '0);
endmodule

// File: rtl/rec_out_fifo.sv
module rec_out_fifo #(
  parameter int DEPTH   = 7,
  parameter int FIELD_W = 16,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_i,
  input  logic [FIELD_W-1:0] wr_q,
  input  logic [FIELD_W-1:0] wr_mag,
  input  logic [FIELD_W-1:0] wr_phase,
  input  logic [FIELD_W-1:0] wr_freq,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic               rd_adv,
  output logic [FIELD_W-1:0] rd_data,
  output logic               empty,
  output logic               full,
  output logic               overflow
);
  import rec_out_fifo_pkg::*;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic                               push;
  logic [PTR_W-1:0]                   wr_ptr, rd_ptr;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] wr_rec, rd_rec;

  always_comb begin
    wr_rec[FLD_I]     = wr_i;
    wr_rec[FLD_Q]     = wr_q;
    wr_rec[FLD_MAG]   = wr_mag;
    wr_rec[FLD_PHASE] = wr_phase;
    wr_rec[FLD_FREQ]  = wr_freq;
  end

  rec_out_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_adv(rd_adv), .push(push),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .empty(empty), .full(full),
    .overflow(overflow)
  );

  rec_out_fifo_store #(.DEPTH(DEPTH), .FIELD_W(FIELD_W), .NFIELDS(NUM_FIELDS)) u_store (
    .clk(clk), .we(push), .waddr(wr_ptr), .wdata(wr_rec),
    .raddr(rd_ptr), .rdata(rd_rec)
  );

  rec_out_fifo_mux #(.FIELD_W(FIELD_W), .NFIELDS(NUM_FIELDS), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst(rst), .fields(rd_rec), .valid(!empty), .sel(rd_sel),
    .data(rd_data)
  );
endmodule

// File: tb/rec_out_fifo_bench.sv
module rec_out_fifo_bench;
  typedef struct packed {
    logic [15:0] i, q, m, p, f;
  } rec_t;

  logic clk = 0, rst = 1, wr_en = 0, rd_adv = 0;
  logic [15:0] wr_i = 0, wr_q = 0, wr_mag = 0, wr_phase = 0, wr_freq = 0;
  logic [2:0] rd_sel = 0;
  logic [15:0] rd_data;
  logic empty, full, overflow;
  int errors = 0, checks = 0;
  bit done = 0;
  rec_t sb[$];

  always #5 clk = ~clk;

  rec_out_fifo u_rec_out_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_i(wr_i), .wr_q(wr_q),
    .wr_mag(wr_mag), .wr_phase(wr_phase), .wr_freq(wr_freq),
    .rd_sel(rd_sel), .rd_adv(rd_adv), .rd_data(rd_data),
    .empty(empty), .full(full), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic rec_t mk(input int s);
    rec_t r;
    r.i = 16'(s * 16'h0101 + 16'h8001);
    r.q = 16'(16'hF000 - s * 3);
    r.m = 16'(16'h8000 | (s * 16'h0111));
    r.p = 16'(s * 16'h1357);
    r.f = 16'(16'h7FFF - s);
    return r;
  endfunction

  // Compare all selector codes against the scoreboard head (R3, R4, R5, R10)
  task automatic scan_head(input string req);
    rec_t h;
    for (int s = 0; s < 8; s++) begin
      logic [15:0] e;
      rd_sel = 3'(s);
      #1;
      e = 16'h0;
      if (sb.size() != 0) begin
        h = sb[0];
        case (s)
          0: e = h.i;
          1: e = h.q;
          2: e = {1'b0, h.m[14:0]};
          3: e = h.p;
          4: e = h.f;
          default: e = 16'h0;
        endcase
      end
      chk(req, rd_data, e);
    end
    chk({req, " empty"}, {15'b0, empty}, {15'b0, sb.size() == 0});
    chk({req, " full"}, {15'b0, full}, {15'b0, sb.size() == 7});
  endtask

  // Driver: one cycle with optional write and advance; scoreboard updated
  task automatic cycle(input bit w, input int seed, input bit a);
    rec_t r = mk(seed);
    bit was_full = (sb.size() == 7);
    bit was_empty = (sb.size() == 0);
    wr_en = w; rd_adv = a;
    {wr_i, wr_q, wr_mag, wr_phase, wr_freq} = {r.i, r.q, r.m, r.p, r.f};
    @(posedge clk); #1;
    wr_en = 0; rd_adv = 0;
    if (a && !was_empty) void'(sb.pop_front());
    if (w && !was_full) sb.push_back(r);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1;
    scan_head("R1 reset");
    chk("R1 overflow", {15'b0, overflow}, 16'h0);
    scan_head("R10 empty");
    // R11: write into empty, readable after one edge
    cycle(1, 1, 0);
    scan_head("R11 first write");
    cycle(1, 2, 0);
    cycle(1, 3, 0);
    scan_head("R3 R5 head");
    // R2 order
    cycle(0, 0, 1);
    scan_head("R2 after advance");
    // R9 mixed write+advance
    cycle(1, 4, 1);
    scan_head("R9 mixed");
    chk("R9 size", 16'(sb.size()), 16'd2);
    // fill to 7 (wraps pointer) R6
    for (int k = 5; k < 10; k++) cycle(1, k, 0);
    scan_head("R6 full");
    chk("R7 no ovf yet", {15'b0, overflow}, 16'h0);
    // R7 dropped write, also with advance
    cycle(1, 50, 0);
    scan_head("R7 dropped");
    chk("R7 overflow set", {15'b0, overflow}, 16'h1);
    cycle(1, 51, 1);
    scan_head("R7 drop with advance");
    // drain, checking order R2
    while (sb.size() != 0) begin
      cycle(0, 0, 1);
      scan_head("R2 drain");
    end
    chk("R7 sticky", {15'b0, overflow}, 16'h1);
    // R8 advance while empty
    cycle(0, 0, 1);
    scan_head("R8 empty advance");
    cycle(1, 60, 0);
    scan_head("R8 new oldest");
    // R11 selector change without clock edge
    rd_sel = 3'd4; #1;
    chk("R11 comb sel", rd_data, mk(60).f);
    rd_sel = 3'd0; #1;
    chk("R11 comb sel", rd_data, mk(60).i);
    // reset clears overflow R1 R7
    cycle(1, 61, 0);
    rst = 1; @(posedge clk); #1; rst = 0;
    sb.delete();
    scan_head("R1 second reset");
    chk("R7 cleared by reset", {15'b0, overflow}, 16'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule